// File: doc/BRIEF.md
# Dual Double-Buffered DAC Code Register Bank

This block is the digital front end of a two-channel, 12-bit parallel-input DAC. A host puts a code on a 12-bit data bus and picks a channel with one address bit. It then strobes an active-low chip select, and the code lands in that channel's input register. A second register stage per channel, the DAC register, holds the code that the converter sees. An active-low load strobe per channel copies the input register into the DAC register.

Because the two stages are separate, the host can preload both input registers one after the other. One shared load strobe then commits both channels on the same clock edge. Either load strobe can also be used alone to update its own channel. An asynchronous active-low reset presets every register. The preset is zero scale, or midscale when the midscale-select input is high. Codes are straight binary. All inputs are sampled in the single system clock domain.

Top module: `dual_dac_regbank`

## Requirements
- R1: Each of the two channels holds a 12-bit input register and a 12-bit DAC register. `dac_a` and `dac_b` always show the DAC register codes unchanged in straight binary, so 0x000 is the minimum and 0xFFF is full scale.
- R2: A write happens at a clock edge where `cs_n` is sampled high and was sampled low at the edge before. At that edge, the input register picked by `sel_b` (0 = channel A, 1 = channel B) takes `din`. Both `sel_b` and `din` are the values sampled at the previous edge. Holding `cs_n` low for several cycles gives exactly one write, and the other channel's input register is left unchanged.
- R3: If `ld_a_n` is sampled low at edge E, `dac_a` takes the input register A value that holds after edge E, and it does so at edge E+1. `ld_b_n` does the same for channel B.
- R4: A load of one channel leaves the other channel's DAC register unchanged.
- R5: When `ld_a_n` and `ld_b_n` are sampled low at the same edge, both DAC registers update at the same later edge.
- R6: While no load is pending for a channel, its DAC register holds its value, whatever writes reach its input register.
- R7: Driving `rst_n` low sets both input registers and both DAC registers to 0x000 at once, without waiting for a clock, when `mid_sel` is low.
- R8: If `mid_sel` is high when `rst_n` goes low, the reset value of all four registers is 0x800 instead.
- R9: If a load is sampled at the same edge that writes that channel's input register, the DAC register receives the newly written code one edge later, not the old one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that presets all registers |
| mid_sel | input | 1 | Reset preset select: 0 gives 0x000, 1 gives 0x800 |
| cs_n | input | 1 | Active-low chip select; its return high commits a write |
| sel_b | input | 1 | Channel address: 0 selects A, 1 selects B |
| din | input | 12 | Parallel write data |
| ld_a_n | input | 1 | Active-low load strobe for channel A |
| ld_b_n | input | 1 | Active-low load strobe for channel B |
| dac_a | output | 12 | DAC register code of channel A |
| dac_b | output | 12 | DAC register code of channel B |

## Verification
The hardest case to reach from the ports is a chip-select release that coincides with a load of the same channel. The input register then changes on the very edge that samples the load, and only the one-cycle-later copy shows whether the new code was taken. Directed sequences set this case up, along with a chip select held low over several changing data words. Seeded random traffic then mixes writes, single and shared loads, and resets with either preset. A bench model built from the requirements predicts every edge of that traffic.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } ch_sel_e;
endpackage

// File: rtl/dac_bus_sampler.sv
module dac_bus_sampler #(
  parameter int unsigned DW  = 12,
  parameter int unsigned NCH = dac_rb_pkg::NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sel,
  input  logic [DW-1:0]  din,
  output logic [NCH-1:0] wr_stb,
  output logic [DW-1:0]  wr_data
);
  logic          cs_q;
  logic          sel_q;
  logic [DW-1:0] din_q;
  logic          cs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sel_q <= 1'b0;
      din_q <= '0;
    end else begin
      cs_q  <= cs_n;
      sel_q <= sel;
      din_q <= din;
    end
  end

  assign cs_rise = cs_n & ~cs_q;
  assign wr_data = din_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    assign wr_stb[ch] = cs_rise && (sel_q == 1'(ch));
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  // R2
  cs_low_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (wr_stb == '0));
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mid_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ld_n,
  output logic          commit,
  output logic [DW-1:0] code
);
  function automatic logic [DW-1:0] preset_code(input logic mid);
    logic [DW-1:0] v;
    v = '0;
    v[DW-1] = mid;
    return v;
  endfunction

  logic [DW-1:0] in_q;
  logic [DW-1:0] dac_q;
  logic          ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_q <= preset_code(mid_sel);
    else if (wr_en) in_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_q <= 1'b0;
    else        ld_q <= ~ld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dac_q <= preset_code(mid_sel);
    else if (ld_q) dac_q <= in_q;
  end

  assign commit = ld_q;
  assign code   = dac_q;

  // R2
  write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (in_q == $past(wr_data)));

  // R3
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> commit ##1 (code == $past(in_q)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(code));
endmodule

// File: rtl/dual_dac_regbank.sv
module dual_dac_regbank #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mid_sel,
  input  logic          cs_n,
  input  logic          sel_b,
  input  logic [DW-1:0] din,
  input  logic          ld_a_n,
  input  logic          ld_b_n,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b
);
  localparam int unsigned NCH = dac_rb_pkg::NCH;

  logic [NCH-1:0] wr_stb;
  logic [DW-1:0]  wr_data;
  logic [NCH-1:0] ld_n_vec;
  logic [NCH-1:0] commit_vec;
  logic [DW-1:0]  code_vec [NCH];

  assign ld_n_vec[dac_rb_pkg::CH_A] = ld_a_n;
  assign ld_n_vec[dac_rb_pkg::CH_B] = ld_b_n;

  dac_bus_sampler #(.DW(DW), .NCH(NCH)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sel     (sel_b),
    .din     (din),
    .wr_stb  (wr_stb),
    .wr_data (wr_data)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dac_channel #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .mid_sel (mid_sel),
      .wr_en   (wr_stb[ch]),
      .wr_data (wr_data),
      .ld_n    (ld_n_vec[ch]),
      .commit  (commit_vec[ch]),
      .code    (code_vec[ch])
    );
  end

  assign dac_a = code_vec[dac_rb_pkg::CH_A];
  assign dac_b = code_vec[dac_rb_pkg::CH_B];

  // R5
  shared_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_a_n && !ld_b_n) |=> (commit_vec == {NCH{1'b1}}));

  // R4
  b_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vec[dac_rb_pkg::CH_A] && !commit_vec[dac_rb_pkg::CH_B]) |=> $stable(dac_b));
endmodule

// File: tb/dual_dac_regbank_tb.sv
module dual_dac_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mid_sel = 1'b0;
  logic        cs_n = 1'b1;
  logic        sel_b = 1'b0;
  logic [11:0] din = '0;
  logic        ld_a_n = 1'b1;
  logic        ld_b_n = 1'b1;
  logic [11:0] dac_a, dac_b;

  int n_cmp = 0;
  int n_bad = 0;

  // model state built from the requirements
  bit        m_csq = 1'b1, m_selq = 1'b0, m_lda = 1'b0, m_ldb = 1'b0;
  bit [11:0] m_dinq = '0, m_ina = '0, m_inb = '0, m_daca = '0, m_dacb = '0;

  always #10 clk = ~clk;

  dual_dac_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .cs_n(cs_n), .sel_b(sel_b),
    .din(din), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .dac_a(dac_a), .dac_b(dac_b)
  );

  function automatic bit [11:0] expect_preset(input bit mid);
    return mid ? 12'd2048 : 12'd0;
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input bit [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit cs, input bit sel, input bit [11:0] d,
                            input bit la, input bit lb);
    bit        wr;
    bit [11:0] nda, ndb;
    wr  = cs && !m_csq;
    nda = m_lda ? m_ina : m_daca;
    ndb = m_ldb ? m_inb : m_dacb;
    if (wr && !m_selq) m_ina = m_dinq;
    if (wr && m_selq)  m_inb = m_dinq;
    m_daca = nda;
    m_dacb = ndb;
    m_lda  = !la;
    m_ldb  = !lb;
    m_csq  = cs;
    m_selq = sel;
    m_dinq = d;
  endtask

  // called just after a falling edge
  task automatic cyc(input bit cs, input bit sel, input bit [11:0] d,
                     input bit la, input bit lb, input string tag);
    cs_n = cs; sel_b = sel; din = d; ld_a_n = la; ld_b_n = lb;
    @(posedge clk);
    model_edge(cs, sel, d, la, lb);
    @(negedge clk);
    chk(tag, dac_a, m_daca);
    chk(tag, dac_b, m_dacb);
  endtask

  task automatic do_reset(input bit mid, input string tag);
    cs_n = 1'b1; ld_a_n = 1'b1; ld_b_n = 1'b1; mid_sel = mid;
    #1 rst_n = 1'b0;
    #2;
    chk(tag, dac_a, expect_preset(mid));
    chk(tag, dac_b, expect_preset(mid));
    m_ina = expect_preset(mid); m_inb = m_ina; m_daca = m_ina; m_dacb = m_ina;
    m_csq = 1'b1; m_selq = 1'b0; m_dinq = '0; m_lda = 1'b0; m_ldb = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_ch(input bit sel, input bit [11:0] d, input string tag);
    cyc(1'b0, sel, d, 1'b1, 1'b1, tag);
    cyc(1'b1, sel, 12'h000, 1'b1, 1'b1, tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    @(negedge clk); @(negedge clk);
    // R7: power-on reset with zero-scale preset
    chk("R7", dac_a, 12'h000);
    chk("R7", dac_b, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: midscale preset, checked before any clock edge
    do_reset(1'b1, "R8");

    // R6: write A, no load, output holds
    write_ch(1'b0, 12'hABC, "R6");
    chk("R6", dac_a, 12'h800);
    // R3: load A alone, one edge of latency
    cyc(1'b1, 1'b0, 12'h000, 1'b0, 1'b1, "R3");
    chk("R3", dac_a, 12'h800);
    cyc(1'b1, 1'b0, 12'h000, 1'b1, 1'b1, "R3");
    chk("R3", dac_a, 12'hABC);
    chk("R4", dac_b, 12'h800);

    // R2: cs_n held low over changing data, single write of last word
    cyc(1'b0, 1'b1, 12'h111, 1'b1, 1'b1, "R2");
    cyc(1'b0, 1'b1, 12'h222, 1'b1, 1'b1, "R2");
    cyc(1'b0, 1'b1, 12'h333, 1'b1, 1'b1, "R2");
    cyc(1'b1, 1'b0, 12'h444, 1'b1, 1'b1, "R2");
    cyc(1'b1, 1'b0, 12'h000, 1'b1, 1'b0, "R2");
    cyc(1'b1, 1'b0, 12'h000, 1'b1, 1'b1, "R2");
    chk("R2", dac_b, 12'h333);
    chk("R4", dac_a, 12'hABC);

    // R5: preload both, commit together
    write_ch(1'b0, 12'h001, "R5");
    write_ch(1'b1, 12'hFFE, "R5");
    chk("R6", dac_a, 12'hABC);
    chk("R6", dac_b, 12'h333);
    cyc(1'b1, 1'b0, 12'h000, 1'b0, 1'b0, "R5");
    chk("R5", dac_a, 12'hABC);
    chk("R5", dac_b, 12'h333);
    cyc(1'b1, 1'b0, 12'h000, 1'b1, 1'b1, "R5");
    chk("R5", dac_a, 12'h001);
    chk("R5", dac_b, 12'hFFE);

    // R9: write and load on the same edge
    cyc(1'b0, 1'b0, 12'h555, 1'b1, 1'b1, "R9");
    cyc(1'b1, 1'b0, 12'h000, 1'b0, 1'b1, "R9");
    chk("R9", dac_a, 12'h001);
    cyc(1'b1, 1'b0, 12'h000, 1'b1, 1'b1, "R9");
    chk("R9", dac_a, 12'h555);

    // R1: full-scale code passes through unchanged
    write_ch(1'b1, 12'hFFF, "R1");
    cyc(1'b1, 1'b0, 12'h000, 1'b1, 1'b0, "R1");
    cyc(1'b1, 1'b0, 12'h000, 1'b1, 1'b1, "R1");
    chk("R1", dac_b, 12'hFFF);

    // R7: zero-scale reset after activity
    do_reset(1'b0, "R7");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 600) == 0) begin
        do_reset(1'(($urandom % 2)), "R7");
      end else begin
        cyc(1'($urandom % 2), 1'($urandom % 2), 12'($urandom),
            (($urandom % 4) != 0), (($urandom % 4) != 0), "R1");
      end
    end

    summary();
    $finish;
  end
endmodule